// File: doc/BRIEF.md
# Core Regulator Voltage Step Controller

This block turns a requested core supply voltage, given in millivolts, into a 5-bit regulator target code. It writes that code into three rail target fields of a single control register in one write, and leaves every other bit of the register as it was read. It then holds `busy` for a settling wait and raises `done` for one cycle. While `done` is high, `code` and `actual_mv` give the resulting setting.

The length of the wait depends on the direction of the change. A higher code costs three microsecond ticks for each code step. A lower code costs no wait. A request that maps to the code already in use causes no write and completes at once. The first request after reset always gets a fixed wait of 84 ticks, because the rails may start out unequal. A request is taken only while `busy` is low. The register contents come in on `reg_rdata`, and the new value leaves on `reg_wr_data` with a one-cycle `reg_wr_en` strobe.

Top module: `vreg_step_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `reg_wr_en` are low, `req_ready` is high, `code` is 0 and `actual_mv` is 700.
- R2: A request below 725 mV selects code 0.
- R3: A request above 1450 mV selects code 31.
- R4: A request from 725 to 1450 mV selects code (mV - 700) / 25, with the remainder dropped.
- R5: `actual_mv` always equals `code` × 25 + 700.
- R6: When a request is taken, in the next cycle `reg_wr_en` is high for exactly that one cycle. `reg_wr_data` then carries the new code in bits [4:0], [13:9] and [22:18], and every other bit equals `reg_rdata` as sampled when the request was taken.
- R7: When the code rises after the first request, `busy` stays high until 3 × (new code - old code) `us_tick` pulses have arrived after the accepting cycle. `busy` then falls in the same cycle that `done` pulses.
- R8: When the code falls, `done` is high and `busy` is low in the cycle after the request is taken.
- R9: A request whose code equals the current code produces no register write. `done` is high in the next cycle.
- R10: The first request after reset always writes, and keeps `busy` for exactly 84 `us_tick` pulses, whatever the code difference.
- R11: While `busy` is high, `req_ready` is low, and `req_valid` has no effect on `code` or on the register write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (not busy) |
| req_mv | input | 12 | Requested voltage in mV |
| reg_rdata | input | 32 | Current contents of the regulator control register |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_data | output | 32 | Register write value |
| busy | output | 1 | Settling wait in progress |
| done | output | 1 | One-cycle completion pulse |
| code | output | 5 | Current regulator target code |
| actual_mv | output | 12 | Voltage of the current code in mV |

## Verification
Some properties are checked on every cycle. These are: all three written fields agree with `code`; a write only follows a taken request, and never repeats the current code after the first request; `busy` only falls on a tick and never drops before one; `done` never overlaps `busy`; a lowering write completes at once; `code` is frozen while busy; and the converter's result brackets the requested voltage. Other behaviour only shows up in the bench's directed scenarios. That covers the exact tick counts of the 84-tick first wait and of the per-step upward waits, the clamp boundaries at 724/725 and 1450/1451 mV, preservation of the unrelated register bits, and the rejection of requests made during a wait.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
  localparam int unsigned NUM_RAILS = 3;
  localparam int unsigned RAIL_LSB [NUM_RAILS] = '{0, 9, 18};
endpackage

// File: rtl/vreg_code_map.sv
module vreg_code_map #(
  parameter int unsigned MV_W    = 12,
  parameter int unsigned CODE_W  = 5,
  parameter int unsigned BASE_MV = 700,
  parameter int unsigned STEP_MV = 25
) (
  input  logic [MV_W-1:0]   mv,
  output logic [CODE_W-1:0] code
);
  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;
  localparam int unsigned LOW_MV   = BASE_MV + STEP_MV;
  localparam int unsigned HIGH_MV  = BASE_MV + STEP_MV * (CODE_MAX - 1);

  logic [MV_W-1:0] offs;
  logic [MV_W-1:0] quot;

  always_comb begin
    offs = mv - MV_W'(BASE_MV);
    quot = offs / MV_W'(STEP_MV);
    if (mv < MV_W'(LOW_MV))
      code = '0;
    else if (mv > MV_W'(HIGH_MV))
      code = '1;
    else
      code = quot[CODE_W-1:0];
  end

  // R4: the chosen in-range code brackets the request from below
  always_comb begin
    if (!$isunknown(mv) && mv >= MV_W'(LOW_MV) && mv <= MV_W'(HIGH_MV))
      assert_code_brackets_R4: assert (
        (int'(code) * STEP_MV + BASE_MV <= int'(mv)) &&
        (int'(mv) < int'(code) * STEP_MV + BASE_MV + STEP_MV));
  end
endmodule

// File: rtl/vreg_settle_timer.sv
module vreg_settle_timer #(
  parameter int unsigned WAIT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              tick,
  output logic              busy,
  output logic              expire
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      busy   <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load && load_val != '0) begin
        cnt  <= load_val;
        busy <= 1'b1;
      end else if (busy && tick) begin
        if (cnt == WAIT_W'(1)) begin
          cnt    <= '0;
          busy   <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - WAIT_W'(1);
        end
      end
    end
  end

  // R7: without a tick the wait cannot end
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !load) |=> busy);
  // R7: the wait ends only on a tick, with a completion pulse
  assert_exit_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(tick) && expire));
endmodule

// File: rtl/vreg_step_ctrl.sv
module vreg_step_ctrl #(
  parameter int unsigned MV_W        = 12,
  parameter int unsigned CODE_W      = 5,
  parameter int unsigned REG_W       = 32,
  parameter int unsigned BASE_MV     = 700,
  parameter int unsigned STEP_MV     = 25,
  parameter int unsigned STEP_US     = 3,
  parameter int unsigned FIRST_STEPS = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MV_W-1:0]   req_mv,
  input  logic [REG_W-1:0]  reg_rdata,
  input  logic              us_tick,
  output logic              reg_wr_en,
  output logic [REG_W-1:0]  reg_wr_data,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] code,
  output logic [MV_W-1:0]   actual_mv
);
  import vreg_pkg::*;

  localparam int unsigned CODE_MAX   = (1 << CODE_W) - 1;
  localparam int unsigned FIRST_WAIT = FIRST_STEPS * STEP_US;
  localparam int unsigned UP_MAX     = CODE_MAX * STEP_US;
  localparam int unsigned MAX_WAIT   = (FIRST_WAIT > UP_MAX) ? FIRST_WAIT : UP_MAX;
  localparam int unsigned WAIT_W     = $clog2(MAX_WAIT + 1);

  logic [CODE_W-1:0] new_code;
  logic [CODE_W-1:0] up_steps;
  logic [WAIT_W-1:0] wait_val;
  logic [REG_W-1:0]  merged;
  logic              first_pend;
  logic              accept;
  logic              do_write;
  logic              timer_busy;
  logic              timer_expire;
  logic              done_imm;

  vreg_code_map #(
    .MV_W(MV_W), .CODE_W(CODE_W), .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
  ) u_map (
    .mv   (req_mv),
    .code (new_code)
  );

  assign busy      = timer_busy;
  assign req_ready = !timer_busy;
  assign accept    = req_valid && !timer_busy;
  assign do_write  = first_pend || (new_code != code);
  assign up_steps  = new_code - code;

  always_comb begin
    if (first_pend)
      wait_val = WAIT_W'(FIRST_WAIT);
    else if (new_code > code)
      wait_val = WAIT_W'(up_steps) * WAIT_W'(STEP_US);
    else
      wait_val = '0;
  end

  always_comb begin
    merged = reg_rdata;
    for (int i = 0; i < NUM_RAILS; i++)
      merged[RAIL_LSB[i] +: CODE_W] = new_code;
  end

  vreg_settle_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (accept && do_write),
    .load_val (wait_val),
    .tick     (us_tick),
    .busy     (timer_busy),
    .expire   (timer_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      first_pend  <= 1'b1;
      code        <= '0;
      actual_mv   <= MV_W'(BASE_MV);
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
      done_imm    <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      done_imm  <= 1'b0;
      if (accept) begin
        if (do_write) begin
          first_pend  <= 1'b0;
          code        <= new_code;
          actual_mv   <= MV_W'(new_code) * MV_W'(STEP_MV) + MV_W'(BASE_MV);
          reg_wr_en   <= 1'b1;
          reg_wr_data <= merged;
          done_imm    <= (wait_val == '0);
        end else begin
          done_imm <= 1'b1;
        end
      end
    end
  end

  assign done = done_imm || timer_expire;

  // R6: a write strobe always follows a taken request
  assert_write_follows_accept_R6: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $past(req_valid && req_ready));

  // R6: all rail fields carry the reported code
  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_field_chk
    assert_field_matches_R6: assert property (@(posedge clk) disable iff (rst)
      reg_wr_en |-> (reg_wr_data[RAIL_LSB[g] +: CODE_W] == code));
  end

  // R9: after the first request, a write implies a changed code
  assert_no_same_write_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !$past(first_pend)) |-> (code != $past(code)));

  // R7: completion never overlaps the wait
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: lowering completes without a wait
  assert_lower_no_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !$past(first_pend) && (code < $past(code))) |-> (done && !busy));

  // R11: the code is frozen while a wait runs
  assert_frozen_when_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(code));

  // R5: reported voltage stays in the representable range
  assert_actual_range_R5: assert property (@(posedge clk) disable iff (rst)
    (actual_mv >= MV_W'(BASE_MV)) &&
    (actual_mv <= MV_W'(BASE_MV + STEP_MV * CODE_MAX)));
endmodule

// File: tb/tb_vreg_step_ctrl.sv
`timescale 1ns/1ps
module tb_vreg_step_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_mv = '0;
  logic [31:0] reg_model = 32'hA5A5_A5A5;
  logic        us_tick = 1'b0;
  logic        reg_wr_en;
  logic [31:0] reg_wr_data;
  logic        busy;
  logic        done;
  logic [4:0]  code;
  logic [11:0] actual_mv;

  int checks = 0;
  int errors = 0;
  int tick_used = 0;
  int wr_count = 0;
  int phase = 0;
  bit finished = 1'b0;
  int cur_code = 0;

  localparam logic [31:0] FIELD_MASK = 32'h007C_3E1F;

  always #2.5 clk = ~clk;

  vreg_step_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mv(req_mv), .reg_rdata(reg_model), .us_tick(us_tick),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .busy(busy),
    .done(done), .code(code), .actual_mv(actual_mv)
  );

  // tick every other cycle; count consumed ticks and writes
  initial begin
    forever begin
      @(negedge clk);
      phase = phase + 1;
      us_tick = phase[0];
      if (busy && us_tick) tick_used = tick_used + 1;
      if (reg_wr_en) begin
        wr_count = wr_count + 1;
        reg_model = reg_wr_data;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_code(input int mv);
    if (mv < 725) return 0;
    if (mv > 1450) return 31;
    return (mv - 700) / 25;
  endfunction

  task automatic do_req(input int mv, input int exp_c, input int exp_wait,
                        input bit exp_wr, input bit poke);
    logic [31:0] snap;
    logic [31:0] exp_data;
    int w0;
    int guard;
    chk(ref_code(mv) == exp_c, "R4 reference", ref_code(mv), exp_c);
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R11 ready when idle", req_ready, 1);
    req_valid = 1'b1;
    req_mv = 12'(mv);
    snap = reg_model;
    w0 = wr_count;
    tick_used = 0;
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk(reg_wr_en == exp_wr, "R6/R9 write strobe", reg_wr_en, exp_wr);
    chk(code == 5'(exp_c), "R2/R3/R4 code", code, exp_c);
    chk(actual_mv == 12'(exp_c * 25 + 700), "R5 actual_mv", actual_mv, exp_c * 25 + 700);
    if (exp_wr) begin
      exp_data = (snap & ~FIELD_MASK) | ({27'd0, 5'(exp_c)}) |
                 ({27'd0, 5'(exp_c)} << 9) | ({27'd0, 5'(exp_c)} << 18);
      chk(reg_wr_data == exp_data, "R6 write data", reg_wr_data, exp_data);
    end
    if (exp_wait == 0) begin
      chk(done == 1'b1, "R8/R9 immediate done", done, 1);
      chk(busy == 1'b0, "R8/R9 not busy", busy, 0);
    end else begin
      chk(busy == 1'b1 && done == 1'b0, "R7/R10 busy after write", busy, 1);
      guard = 0;
      while (busy && guard < 1000) begin
        if (poke && guard < 4) begin
          req_valid = 1'b1;
          req_mv = 12'd800;
          chk(req_ready == 1'b0, "R11 ready low while busy", req_ready, 0);
        end else begin
          req_valid = 1'b0;
        end
        @(negedge clk); #1;
        guard++;
      end
      req_valid = 1'b0;
      chk(done == 1'b1, "R7/R10 done at end of wait", done, 1);
      chk(tick_used == exp_wait, "R7/R10 ticks waited", tick_used, exp_wait);
      chk(code == 5'(exp_c), "R11 code unchanged by busy request", code, exp_c);
    end
    chk((wr_count - w0) == int'(exp_wr), "R6/R9/R11 write count", wr_count - w0, int'(exp_wr));
    @(negedge clk); #1;
    chk(done == 1'b0, "R7 done is one cycle", done, 0);
    cur_code = exp_c;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk); #1;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(reg_wr_en == 1'b0, "R1 wr_en", reg_wr_en, 0);
    chk(code == 5'd0, "R1 code", code, 0);
    chk(actual_mv == 12'd700, "R1 actual", actual_mv, 700);
  endtask

  task automatic t_first();      do_req(1100, 16, 84, 1'b1, 1'b0); endtask // R10
  task automatic t_equal();      do_req(1110, 16, 0, 1'b0, 1'b0);  endtask // R9
  task automatic t_raise();      do_req(1275, 23, 21, 1'b1, 1'b0); endtask // R7
  task automatic t_lower();      do_req(900, 8, 0, 1'b1, 1'b0);    endtask // R8
  task automatic t_low_clamp();  do_req(600, 0, 0, 1'b1, 1'b0);    endtask // R2
  task automatic t_high_clamp(); do_req(1500, 31, 93, 1'b1, 1'b0); endtask // R3
  task automatic t_edges();
    do_req(724, 0, 0, 1'b1, 1'b0);   // R2 boundary
    do_req(725, 1, 3, 1'b1, 1'b0);   // R4 boundary, R7 single step
    do_req(1450, 30, 87, 1'b1, 1'b1); // R4 top, R11 requests while busy
    do_req(1451, 31, 3, 1'b1, 1'b0); // R3 boundary
    do_req(1449, 29, 0, 1'b1, 1'b0); // R4 lower
  endtask
  task automatic t_first_again();
    t_reset();
    do_req(690, 0, 84, 1'b1, 1'b0);  // R10 first write even for code 0
  endtask

  initial begin
    t_reset();
    t_first();
    t_equal();
    t_raise();
    t_lower();
    t_low_clamp();
    t_high_clamp();
    t_edges();
    t_first_again();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule